// File: doc/BRIEF.md
# SDRAM Write Burst Termination Sequencer

This block serves one write burst at a time inside an SDRAM controller. A request names a bank, row, start column and a count of wanted data beats. It also says whether the burst uses the fixed programmed length or the open-ended full-page mode. The block opens the row with ACTIVE and waits the row-to-column delay. It then issues WRITE with auto precharge off and streams the caller's data on DQ. It closes the bank itself with an explicitly timed PRECHARGE.

A fixed burst may run its full length or stop early after a chosen beat. A full-page burst always stops after the wanted beat. Every beat after the last wanted one is masked with DQM up to and including the PRECHARGE cycle, so the device never stores it. The PRECHARGE comes exactly the write-recovery time after the last wanted beat. The block then stays busy until the precharge time has run out. A READ request arriving during the burst cuts the write short. The READ goes out on the next clock, the block stops driving DQ, and a strobe marks the cycle, CAS latency later, in which read data is due.

All timings are given as parameters in picoseconds and rounded up to whole clocks.

Top module: `wburst_term`

## Requirements
- R1: While reset is held and after it is released, busy is low, the command is NOP (`{ras_n,cas_n,we_n}` = 111), DQM is high, DQ is not driven and the read strobe is low.
- R2: An accepted request issues ACTIVE (011) with the row on the address and the bank on the bank output. WRITE (100) follows tRCD cycles later with the start column on the low address bits and address bit 10 low (no auto precharge).
- R3: A fixed-length burst whose beat count is 0 or at least the burst length writes all burst-length beats. Its PRECHARGE (010) comes burst_length-1+tWR cycles after the WRITE, to the same bank with address bit 10 low.
- R4: A truncated burst (fixed length with fewer beats wanted, or any full-page burst) writes only the wanted beats. DQM is high on every cycle after the last wanted beat through the PRECHARGE cycle, so no later beat reaches the array.
- R5: A full-page burst (beat count 0 taken as 1) drives DQ from the WRITE cycle through the PRECHARGE cycle. A fixed burst drives DQ for burst-length cycles at most.
- R6: tWR in clocks is one plus the write-recovery time divided by the clock period, rounded up. PRECHARGE is issued exactly tWR cycles after the cycle of the last wanted beat.
- R7: busy stays high from the ACTIVE cycle until tRP cycles (tRP time divided by clock period, rounded up, at least 1) after the PRECHARGE. No ACTIVE is issued sooner than tRP cycles after a PRECHARGE.
- R8: Every cycle that carries no command drives NOP. While busy is low, DQ is not driven.
- R9: A request presented while busy is ignored.
- R10: A read request sampled during the burst before the PRECHARGE cycle ends the write. READ (101) goes out on the next cycle with the read bank and column, address bit 10 low, DQM low and DQ released. No PRECHARGE follows, and busy drops on the cycle after the READ.
- R11: rd_strobe is high for one cycle, CAS_LAT cycles after the READ cycle.
- R12: data_take is high exactly on the wanted beat cycles. On those cycles DQ carries wr_data and DQM is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request, taken when busy is low |
| req_full_page | input | 1 | 1: full-page burst, 0: fixed length |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ADDR_W | Row to open |
| req_col | input | COL_W | Start column |
| req_beats | input | COL_W+1 | Number of wanted beats |
| wr_data | input | DQ_W | Write data for the current beat |
| data_take | output | 1 | wr_data consumed this cycle |
| rd_req | input | 1 | Read that interrupts the running write |
| rd_bank | input | BANK_W | Bank of the interrupting read |
| rd_col | input | COL_W | Column of the interrupting read |
| busy | output | 1 | Sequencer owns the bank |
| sd_cmd | output | 3 | {ras_n,cas_n,we_n} |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_dq_out | output | DQ_W | Write data to DQ |
| sd_dq_oe | output | 1 | DQ output enable |
| sd_dqm | output | 1 | Data mask |
| rd_strobe | output | 1 | Read data due this cycle |

## Verification
The bench targets several corner cases. A one-beat truncation forces masking of the rest of the burst and the PRECHARGE. A design that leaves DQM low there lets the bench's memory model store a beat it should not. A fixed burst with a beat count of exactly the burst length, or zero, must run to completion. A comparison off by one there moves the PRECHARGE one cycle, which the per-cycle command trace and the write-recovery check catch. Full-page bursts that wrap the column space and reads on the very WRITE cycle test the interrupt path. A design that still precharges, keeps driving DQ or drops busy early breaks the cycle trace there. Requests presented while busy expose a sequencer that accepts them.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
   localparam logic [2:0] CMD_NOP = 3'b111;
   localparam logic [2:0] CMD_ACT = 3'b011;
   localparam logic [2:0] CMD_RD  = 3'b101;
   localparam logic [2:0] CMD_WR  = 3'b100;
   localparam logic [2:0] CMD_PRE = 3'b010;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ACT, ST_RCD, ST_XFER, ST_RPW, ST_RD
   } wbt_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int at_least_one(input int v);
      return (v < 1) ? 1 : v;
   endfunction
endpackage

// File: rtl/wbt_wait_ctr.sv
module wbt_wait_ctr #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             done
);
   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/wbt_delay.sv
module wbt_delay #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (DEPTH == 0) begin : g_pass
         assign dout = din;
      end else begin : g_pipe
         logic [DEPTH-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[DEPTH-2 >= 0 ? DEPTH-2 : 0 : 0], din} & {DEPTH{1'b1}};
         end
         if (DEPTH == 1) begin : g_one
            assign dout = sh_q[0];
         end else begin : g_many
            assign dout = sh_q[DEPTH-1];
         end
      end
   endgenerate
endmodule

// File: rtl/wburst_term.sv
module wburst_term
   import wbt_pkg::*;
#(
   parameter int BANK_W    = 2,
   parameter int ADDR_W    = 13,
   parameter int COL_W     = 10,
   parameter int DQ_W      = 16,
   parameter int BURST_LEN = 4,
   parameter int CLK_PS    = 20000,
   parameter int TWR_PS    = 7500,
   parameter int TRP_PS    = 45000,
   parameter int TRCD_PS   = 30000,
   parameter int CAS_LAT   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_full_page,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ADDR_W-1:0] req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [COL_W:0]    req_beats,
   input  logic [DQ_W-1:0]   wr_data,
   output logic              data_take,
   input  logic              rd_req,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [COL_W-1:0]  rd_col,
   output logic              busy,
   output logic [2:0]        sd_cmd,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [DQ_W-1:0]   sd_dq_out,
   output logic              sd_dq_oe,
   output logic              sd_dqm,
   output logic              rd_strobe
);
   localparam int TWR_CYC  = 1 + ceil_div(TWR_PS, CLK_PS);
   localparam int TRP_CYC  = at_least_one(ceil_div(TRP_PS, CLK_PS));
   localparam int TRCD_CYC = at_least_one(ceil_div(TRCD_PS, CLK_PS));
   localparam int BEAT_W   = COL_W + 1;
   localparam int CNT_W    = $clog2((1 << COL_W) + TWR_CYC + 2) + 1;
   localparam int WAIT_W   = $clog2(TRP_CYC + TRCD_CYC + 1) + 1;

   generate
      if (COL_W > 10 || ADDR_W < 11) begin : g_bad_addr
         $error("column must sit below address bit 10");
      end
      if (BURST_LEN != 1 && BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
         $error("burst length must be 1, 2, 4 or 8");
      end
      if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
         $error("CAS latency out of range");
      end
      if (TRP_CYC > 200 || TWR_CYC > 200) begin : g_bad_tim
         $error("timing too long for the checker counters");
      end
   endgenerate

   wbt_state_e state_q, state_d;
   logic [BANK_W-1:0] bank_q, rdbank_q;
   logic [ADDR_W-1:0] row_q;
   logic [COL_W-1:0]  col_q, rdcol_q;
   logic              full_q;
   logic [BEAT_W-1:0] want_q, want_d;
   logic [CNT_W-1:0]  cyc_q, pre_at_q;
   logic              wait_load, wait_done;
   logic [WAIT_W-1:0] wait_val;
   logic              at_pre, beat;

   // wanted beats: fixed bursts clamp to the burst length, full page needs one
   always_comb begin
      if (req_full_page)
         want_d = (req_beats == '0) ? BEAT_W'(1) : req_beats;
      else if (req_beats == '0 || req_beats >= BEAT_W'(BURST_LEN))
         want_d = BEAT_W'(BURST_LEN);
      else
         want_d = req_beats;
   end

   assign at_pre = (state_q == ST_XFER) && (cyc_q == pre_at_q);
   assign beat   = (state_q == ST_XFER) && (cyc_q < CNT_W'(want_q));

   always_comb begin
      state_d   = state_q;
      wait_load = 1'b0;
      wait_val  = '0;
      unique case (state_q)
         ST_IDLE: if (req_valid) state_d = ST_ACT;
         ST_ACT: begin
            if (TRCD_CYC > 1) begin
               state_d   = ST_RCD;
               wait_load = 1'b1;
               wait_val  = WAIT_W'(TRCD_CYC - 2);
            end else begin
               state_d = ST_XFER;
            end
         end
         ST_RCD: if (wait_done) state_d = ST_XFER;
         ST_XFER: begin
            if (at_pre) begin
               if (TRP_CYC > 1) begin
                  state_d   = ST_RPW;
                  wait_load = 1'b1;
                  wait_val  = WAIT_W'(TRP_CYC - 2);
               end else begin
                  state_d = ST_IDLE;
               end
            end else if (rd_req) begin
               state_d = ST_RD;
            end
         end
         ST_RPW: if (wait_done) state_d = ST_IDLE;
         ST_RD:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bank_q   <= '0;
         row_q    <= '0;
         col_q    <= '0;
         full_q   <= 1'b0;
         want_q   <= '0;
         pre_at_q <= '0;
         cyc_q    <= '0;
         rdbank_q <= '0;
         rdcol_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_valid) begin
            bank_q   <= req_bank;
            row_q    <= req_row;
            col_q    <= req_col;
            full_q   <= req_full_page;
            want_q   <= want_d;
            pre_at_q <= CNT_W'(want_d) + CNT_W'(TWR_CYC - 1);
         end
         if (state_q == ST_XFER) cyc_q <= cyc_q + 1'b1;
         else                    cyc_q <= '0;
         if (state_q == ST_XFER && !at_pre && rd_req) begin
            rdbank_q <= rd_bank;
            rdcol_q  <= rd_col;
         end
      end
   end

   wbt_wait_ctr #(.WIDTH(WAIT_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wait_load),
      .load_val (wait_val),
      .done     (wait_done)
   );

   wbt_delay #(.DEPTH(CAS_LAT)) u_rdlat (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (state_q == ST_RD),
      .dout  (rd_strobe)
   );

   always_comb begin
      sd_cmd    = CMD_NOP;
      sd_ba     = bank_q;
      sd_addr   = '0;
      sd_dqm    = 1'b1;
      sd_dq_oe  = 1'b0;
      sd_dq_out = '0;
      data_take = beat;
      unique case (state_q)
         ST_ACT: begin
            sd_cmd  = CMD_ACT;
            sd_addr = row_q;
         end
         ST_XFER: begin
            if (cyc_q == '0) begin
               sd_cmd  = CMD_WR;
               sd_addr = ADDR_W'(col_q);
            end else if (at_pre) begin
               sd_cmd = CMD_PRE;
            end
            sd_dqm    = !beat;
            sd_dq_oe  = full_q || (cyc_q < CNT_W'(BURST_LEN));
            sd_dq_out = beat ? wr_data : '0;
         end
         ST_RD: begin
            sd_cmd  = CMD_RD;
            sd_ba   = rdbank_q;
            sd_addr = ADDR_W'(rdcol_q);
            sd_dqm  = 1'b0;
         end
         default: ;
      endcase
   end

   assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/wbt_checker.sv
module wbt_checker
   import wbt_pkg::*;
#(
   parameter int CLK_PS = 20000,
   parameter int TWR_PS = 7500,
   parameter int TRP_PS = 45000,
   parameter int ADDR_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        sd_cmd,
   input logic [ADDR_W-1:0] sd_addr,
   input logic              sd_dqm,
   input logic              sd_dq_oe,
   input logic              data_take,
   input logic              busy
);
   localparam int TWR_CYC = 1 + ceil_div(TWR_PS, CLK_PS);
   localparam int TRP_CYC = at_least_one(ceil_div(TRP_PS, CLK_PS));

   logic [7:0] since_wr, since_pre;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_wr  <= 8'hFF;
         since_pre <= 8'hFF;
      end else begin
         if (data_take)               since_wr <= 8'd1;
         else if (since_wr != 8'hFF)  since_wr <= since_wr + 8'd1;
         if (sd_cmd == CMD_PRE)       since_pre <= 8'd1;
         else if (since_pre != 8'hFF) since_pre <= since_pre + 8'd1;
      end
   end

   assert_a10_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_WR || sd_cmd == CMD_RD || sd_cmd == CMD_PRE) |-> !sd_addr[10]);

   assert_wr_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_PRE) |-> (since_wr >= 8'(TWR_CYC)));

   assert_precharge_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_ACT) |-> (since_pre >= 8'(TRP_CYC)));

   assert_pre_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_PRE) |-> (sd_dqm && !data_take));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sd_cmd == CMD_NOP && !sd_dq_oe));

   assert_read_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_RD) |-> (!sd_dq_oe && !data_take));

   assert_take_unmasked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      data_take |-> (!sd_dqm && sd_dq_oe));
endmodule

bind wburst_term wbt_checker #(
   .CLK_PS (CLK_PS),
   .TWR_PS (TWR_PS),
   .TRP_PS (TRP_PS),
   .ADDR_W (ADDR_W)
) u_wbt_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sd_cmd    (sd_cmd),
   .sd_addr   (sd_addr),
   .sd_dqm    (sd_dqm),
   .sd_dq_oe  (sd_dq_oe),
   .data_take (data_take),
   .busy      (busy)
);

// File: tb/wburst_term_bench.sv
module wburst_term_bench;
   localparam int BL   = 4;
   localparam int CL   = 2;
   localparam int TWR  = 2;   // 1 + ceil(7500/20000)
   localparam int TRP  = 3;   // ceil(45000/20000)
   localparam int TRCD = 2;   // ceil(30000/20000)
   localparam bit [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                        C_WR = 3'b100, C_PRE = 3'b010;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_full_page = 0, rd_req = 0;
   logic [1:0] req_bank = 0, rd_bank = 0;
   logic [12:0] req_row = 0;
   logic [9:0] req_col = 0, rd_col = 0;
   logic [10:0] req_beats = 0;
   logic [15:0] wr_data = 0;
   logic data_take, busy, sd_dq_oe, sd_dqm, rd_strobe;
   logic [2:0] sd_cmd;
   logic [1:0] sd_ba;
   logic [12:0] sd_addr;
   logic [15:0] sd_dq_out;

   int n_chk = 0, n_fail = 0, gcyc = 0, last_pre_g = -1000;
   logic [15:0] mem [1024];

   always #10 clk = ~clk;

   wburst_term u_wburst_term (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_full_page(req_full_page),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_beats(req_beats),
      .wr_data(wr_data), .data_take(data_take), .rd_req(rd_req), .rd_bank(rd_bank),
      .rd_col(rd_col), .busy(busy), .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr),
      .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm), .rd_strobe(rd_strobe)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int t, input int o);
      return 16'(((t * 37) + (o * 131)) ^ 16'hA5C3);
   endfunction

   function automatic int want_of(input bit full, input int beats);
      if (full) return (beats == 0) ? 1 : beats;
      return (beats == 0 || beats >= BL) ? BL : beats;
   endfunction

   task automatic run_txn(input int tid, input bit full, input logic [1:0] bank,
                          input logic [12:0] row, input logic [9:0] col, input int beats,
                          input int rd_c, input bit junk);
      int want = want_of(full, beats);
      int P = want - 1 + TWR;
      bit rdm = (rd_c >= 0);
      int ro = rdm ? TRCD + rd_c + 1 : -1;
      int o_last = (rdm ? ro + 1 : TRCD + P + TRP) + CL + 1;
      int nwr = rdm ? ((rd_c + 1 < want) ? rd_c + 1 : want) : want;
      bit bon = 0;
      int bcol = 0, bi = 0, last_wr = -1000;
      logic [1:0] rbank = bank ^ 2'b01;
      logic [9:0] rcol = col ^ 10'h155;
      for (int i = 0; i < 1024; i++) mem[i] = 16'hDEAD;
      chk(!busy, "R7", "idle before request", 32'(busy), 0);
      req_valid = 1; req_full_page = full; req_bank = bank; req_row = row;
      req_col = col; req_beats = 11'(beats); rd_req = 0; rd_bank = rbank; rd_col = rcol;
      @(posedge clk); @(negedge clk);
      for (int o = 0; o <= o_last; o++) begin
         int c = o - TRCD;
         bit [2:0] ec;
         bit eb, ebeat, edqm, eoe, est;
         string rc;
         wr_data = pat(tid, o);
         rd_req = rdm && (o == TRCD + rd_c);
         if (junk && o <= 1) begin
            req_valid = 1; req_row = ~row; req_col = col ^ 10'h3; req_beats = 7;
            req_full_page = ~full;
         end else req_valid = 0;
         #1;
         if (o == 0) ec = C_ACT;
         else if (rdm && o == ro) ec = C_RD;
         else if (rdm && o > ro) ec = C_NOP;
         else if (c == 0) ec = C_WR;
         else if (c == P) ec = C_PRE;
         else ec = C_NOP;
         eb = rdm ? (o <= ro) : (o < TRCD + P + TRP);
         ebeat = (c >= 0) && (c < want) && (!rdm || o < ro);
         edqm = ebeat ? 1'b0 : ((rdm && o == ro) ? 1'b0 : 1'b1);
         eoe = (c >= 0) && (c <= P) && (full || c < BL) && (!rdm || o < ro);
         est = rdm && (o == ro + CL);
         rc = (ec == C_ACT || ec == C_WR) ? "R2" : (ec == C_PRE) ? "R6" :
              (ec == C_RD) ? "R10" : (junk && o <= 3) ? "R9" : "R8";
         chk(sd_cmd == ec, rc, "command", 32'(sd_cmd), 32'(ec));
         chk(busy == eb, rdm ? "R10" : "R7", "busy", 32'(busy), 32'(eb));
         chk(sd_dqm == edqm, (c > want - 1) ? "R4" : "R3", "dqm", 32'(sd_dqm), 32'(edqm));
         chk(data_take == ebeat, "R12", "data_take", 32'(data_take), 32'(ebeat));
         chk(sd_dq_oe == eoe, "R5", "dq_oe", 32'(sd_dq_oe), 32'(eoe));
         chk(rd_strobe == est, "R11", "rd_strobe", 32'(rd_strobe), 32'(est));
         if (ebeat) chk(sd_dq_out == wr_data, "R12", "dq data", 32'(sd_dq_out), 32'(wr_data));
         if (ec == C_ACT) chk(sd_addr == row && sd_ba == bank, "R2", "act addr", 32'(sd_addr), 32'(row));
         if (ec == C_WR)  chk(sd_addr == 13'(col), "R2", "write addr", 32'(sd_addr), 32'(col));
         if (ec == C_PRE) chk(!sd_addr[10] && sd_ba == bank, "R3", "pre addr", 32'(sd_addr), 0);
         if (ec == C_RD)  chk(sd_addr == 13'(rcol) && sd_ba == rbank, "R10", "read addr",
                              32'(sd_addr), 32'(rcol));
         // single-bank device model
         if (sd_cmd == C_PRE) begin
            bon = 0;
            chk(o - last_wr >= TWR, "R6", "write recovery", 32'(o - last_wr), 32'(TWR));
            last_pre_g = gcyc;
         end
         if (sd_cmd == C_RD) bon = 0;
         if (sd_cmd == C_ACT)
            chk(gcyc - last_pre_g >= TRP, "R7", "act after pre", 32'(gcyc - last_pre_g), 32'(TRP));
         if (sd_cmd == C_WR) begin bon = 1; bcol = int'(sd_addr[9:0]); bi = 0; end
         if (bon) begin
            if (!sd_dqm) begin mem[(bcol + bi) % 1024] = sd_dq_out; last_wr = o; end
            bi++;
            if (!full && bi == BL) bon = 0;
         end
         gcyc++;
         @(negedge clk);
      end
      rd_req = 0; req_valid = 0;
      for (int i = 0; i < nwr; i++)
         chk(mem[(col + i) % 1024] == pat(tid, TRCD + i), full ? "R5" : "R3", "stored beat",
             32'(mem[(col + i) % 1024]), 32'(pat(tid, TRCD + i)));
      for (int i = nwr; i < nwr + 4; i++)
         chk(mem[(col + i) % 1024] == 16'hDEAD, "R4", "masked beat unwritten",
             32'(mem[(col + i) % 1024]), 32'hDEAD);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (2) @(negedge clk);
      chk(!busy && sd_cmd == C_NOP && sd_dqm && !sd_dq_oe && !rd_strobe, "R1", "in reset",
          32'({busy, sd_cmd, sd_dqm, sd_dq_oe}), 32'h1E);
      rst_n = 1;
      @(negedge clk); @(negedge clk);
      chk(!busy && sd_cmd == C_NOP && sd_dqm && !sd_dq_oe && !rd_strobe, "R1", "after reset",
          32'({busy, sd_cmd, sd_dqm, sd_dq_oe}), 32'h1E);
      run_txn(1, 0, 2'd1, 13'h0123, 10'd8, 0, -1, 0);     // R3 full fixed burst
      run_txn(2, 0, 2'd2, 13'h0AA0, 10'd16, BL, -1, 0);   // R3 count equal to length
      run_txn(3, 0, 2'd0, 13'h1F00, 10'd24, 1, -1, 0);    // R4 one-beat truncation
      run_txn(4, 0, 2'd3, 13'h0042, 10'd32, 3, -1, 0);    // R4
      run_txn(5, 1, 2'd1, 13'h0777, 10'd1020, 6, -1, 0);  // R5 column wrap
      run_txn(6, 1, 2'd0, 13'h0001, 10'd100, 0, -1, 0);   // R5 zero count
      run_txn(7, 0, 2'd2, 13'h0303, 10'd40, 0, 0, 0);     // R10 read on WRITE cycle
      run_txn(8, 1, 2'd3, 13'h0505, 10'd200, 10, 4, 0);   // R10 R11 full page
      run_txn(9, 0, 2'd1, 13'h0606, 10'd48, 2, -1, 1);    // R9 request while busy
      for (int t = 10; t < 50; t++) begin
         bit full = ($urandom % 3) == 0;
         int beats = full ? int'($urandom % 40) : int'($urandom % (BL + 2));
         int w = want_of(full, beats);
         int rdc = (($urandom % 4) == 0) ? int'($urandom % (w - 1 + TWR)) : -1;
         logic [9:0] col = 10'($urandom);
         if (!full) col = col & ~10'(BL - 1);
         run_txn(t, full, 2'($urandom), 13'($urandom), col, beats, rdc, ($urandom % 5) == 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule